// File: doc/BRIEF.md
# Latched 16-bit Down-Counter Timer

This block is a down-counting interval timer. It keeps two byte-wide reload latches apart from the running counter. Software reaches it through four byte offsets on a simple register bus. The counter is loaded from the latches only when the high byte is written at the counter offset. After that it counts down by one on every clock. When it passes zero it raises an interrupt flag and can drive a waveform onto bit 7 of a peripheral port.

Two mode bits pick the behaviour. In one-shot mode each load gives exactly one flag event, and the counter keeps wrapping without ever setting the flag again. In free-running mode the counter reloads automatically after every zero, which gives evenly spaced flag events and a square wave on the port pin. The waveform reaches the pin only when the output mode bit and the pin's direction bit are both set. In every other case the pin carries the port's ordinary data bit.

Top module: `timer16_latched`

## Requirements
- R1: After reset the interrupt flag is 0, both latches read 0, and the waveform level is high.
- R2: A write at offset 0 or offset 2 loads the low latch, which reads back at offset 2. Neither write changes the counter's one-per-clock decrement.
- R3: A write at offset 1 loads the high latch and clears the flag. In the same edge it sets the counter to {written byte, low latch}. From the next clock on the counter falls by 1 per clock. The counter reads at offset 0 (low byte) and offset 1 (high byte).
- R4: A write at offset 3 loads the high latch, which reads back at offset 3, and clears the flag. It leaves the counter untouched.
- R5: A read strobe at offset 0 clears the flag. Read strobes at offsets 1, 2 and 3 leave it unchanged.
- R6: The flag becomes 1 on the clock edge at which a counter value of 0 is seen. When loaded with N, the flag is visible N+1 clocks after the load edge, while the counter reads 0xFFFF.
- R7: In one-shot mode (mode bit 0 = 0) only one flag event occurs per load. The counter keeps wrapping through 0 and never sets the flag again until the next offset-1 write.
- R8: In free-running mode (mode bit 0 = 1), after the zero the counter shows 0xFFFF for one clock and then the 16-bit latch value. The period is latch + 2 clocks.
- R9: On an offset-1 write the waveform level goes low. In one-shot mode it goes high on the zero event.
- R10: In free-running mode the waveform level toggles on every zero event.
- R11: The port pin carries the waveform level when mode bit 1 and the direction input are both 1. Otherwise it carries the port data input.
- R12: A zero event in the same clock as a flag-clearing read leaves the flag set. An offset-1 write overrides everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset 0..3 |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_rdata | output | 8 | Read data for the addressed offset |
| mode_sel | input | 2 | Bit 1 enables the waveform output, bit 0 selects free-running |
| pin_dir7 | input | 1 | Direction bit of port pin 7 (1 = output) |
| pin_data7 | input | 1 | Ordinary port data for pin 7 |
| irq_flag | output | 1 | Timer interrupt flag |
| pin_out7 | output | 1 | Level driven on port pin 7 |

## Verification
Every cycle, the assertions check the counter arithmetic: the load value, the decrement, and the reload one clock after the zero. They also check how the flag is set and cleared, the waveform level after each zero event, and that one-shot mode disarms after firing. Other behaviour only the bench's scenarios can show. These are the exact cycle at which the flag appears for a given latch value, the absence of a second flag after a full 65536-clock wrap, the free-running period across several reloads, and the race between a zero event and a read at offset 0.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_LAT_LO = 2'd2,
        REG_LAT_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wave_en;
        logic continuous;
    } mode_t;

    typedef struct packed {
        logic lat_lo_we;
        logic lat_hi_we;
        logic load;
        logic flag_clr;
    } bus_evt_t;

    function automatic bus_evt_t decode_bus(logic [ADDR_W-1:0] addr, logic wr, logic rd);
        bus_evt_t e;
        e.lat_lo_we = wr && (addr == REG_CNT_LO || addr == REG_LAT_LO);
        e.lat_hi_we = wr && (addr == REG_CNT_HI || addr == REG_LAT_HI);
        e.load      = wr && (addr == REG_CNT_HI);
        e.flag_clr  = (wr && (addr == REG_CNT_HI || addr == REG_LAT_HI)) ||
                      (rd && addr == REG_CNT_LO);
        return e;
    endfunction

endpackage

// File: rtl/timer16_regs.sv
module timer16_regs
    import timer16_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  latch_q,
    output logic [CNT_W-1:0]  load_val,
    output bus_evt_t          evt,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] lat_lo_q;
    logic [BYTE_W-1:0] lat_hi_q;

    assign evt      = decode_bus(addr, wr, rd);
    assign latch_q  = {lat_hi_q, lat_lo_q};
    assign load_val = {wdata, lat_lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo_q <= '0;
            lat_hi_q <= '0;
        end else begin
            if (evt.lat_lo_we) lat_lo_q <= wdata;
            if (evt.lat_hi_we) lat_hi_q <= wdata;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(addr))
            REG_CNT_LO: rdata = cnt[BYTE_W-1:0];
            REG_CNT_HI: rdata = cnt[CNT_W-1:BYTE_W];
            REG_LAT_LO: rdata = lat_lo_q;
            REG_LAT_HI: rdata = lat_hi_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/timer16_count.sv
module timer16_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] latch,
    input  logic             continuous,
    input  logic             armed,
    output logic [CNT_W-1:0] cnt_q,
    output logic             reload_pend,
    output logic             zero_hit
);
    logic at_zero;

    assign at_zero  = (cnt_q == '0);
    assign zero_hit = at_zero && !load && !reload_pend && (continuous || armed);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            reload_pend <= 1'b0;
        end else if (load) begin
            cnt_q       <= load_val;
            reload_pend <= 1'b0;
        end else if (reload_pend) begin
            cnt_q       <= latch;
            reload_pend <= 1'b0;
        end else begin
            cnt_q       <= cnt_q - 1'b1;
            reload_pend <= at_zero && continuous;
        end
    end
endmodule

// File: rtl/timer16_event.sv
module timer16_event
    import timer16_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  flag_clr,
    input  logic  zero_hit,
    input  mode_t mode,
    input  logic  pin_dir7,
    input  logic  pin_data7,
    output logic  irq_flag,
    output logic  armed,
    output logic  wave_level,
    output logic  pin_out7
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag   <= 1'b0;
            armed      <= 1'b0;
            wave_level <= 1'b1;
        end else if (load) begin
            irq_flag   <= 1'b0;
            armed      <= 1'b1;
            wave_level <= 1'b0;
        end else if (zero_hit) begin
            irq_flag   <= 1'b1;
            armed      <= 1'b0;
            wave_level <= mode.continuous ? !wave_level : 1'b1;
        end else if (flag_clr) begin
            irq_flag   <= 1'b0;
        end
    end

    assign pin_out7 = (mode.wave_en && pin_dir7) ? wave_level : pin_data7;
endmodule

// File: rtl/timer16_latched.sv
module timer16_latched
    import timer16_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [1:0]        mode_sel,
    input  logic              pin_dir7,
    input  logic              pin_data7,
    output logic              irq_flag,
    output logic              pin_out7
);
    localparam int CNT_W = 2 * BYTE_W;

    mode_t            mode;
    bus_evt_t         evt;
    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_q;
    logic             reload_pend;
    logic             zero_hit;
    logic             armed;
    logic             wave_level;

    assign mode = mode_t'(mode_sel);

    timer16_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .cnt      (cnt_q),
        .latch_q  (latch_q),
        .load_val (load_val),
        .evt      (evt),
        .rdata    (bus_rdata)
    );

    timer16_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst         (rst),
        .load        (evt.load),
        .load_val    (load_val),
        .latch       (latch_q),
        .continuous  (mode.continuous),
        .armed       (armed),
        .cnt_q       (cnt_q),
        .reload_pend (reload_pend),
        .zero_hit    (zero_hit)
    );

    timer16_event u_event (
        .clk        (clk),
        .rst        (rst),
        .load       (evt.load),
        .flag_clr   (evt.flag_clr),
        .zero_hit   (zero_hit),
        .mode       (mode),
        .pin_dir7   (pin_dir7),
        .pin_data7  (pin_data7),
        .irq_flag   (irq_flag),
        .armed      (armed),
        .wave_level (wave_level),
        .pin_out7   (pin_out7)
    );
endmodule

// File: rtl/timer16_chk.sv
module timer16_chk #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        mode_sel,
    input logic              pin_dir7,
    input logic              pin_data7,
    input logic              irq_flag,
    input logic              pin_out7,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  latch,
    input logic              reload_pend,
    input logic              zero_hit,
    input logic              armed,
    input logic              wave_level
);
    logic load;
    assign load = bus_wr && (bus_addr == 2'd1);

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        load |=> (!irq_flag && cnt == {$past(bus_wdata), $past(latch[BYTE_W-1:0])})); // R3
    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (!load && !reload_pend) |=> cnt == $past(cnt) - 1'b1); // R3
    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (reload_pend && !load) |=> cnt == $past(latch)); // R8
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        zero_hit |=> irq_flag); // R6
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd0 && !zero_hit) |=> !irq_flag); // R5
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $past(zero_hit)); // R7
    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
        (zero_hit && !mode_sel[0]) |=> (!armed && wave_level)); // R9
    AST_WAVE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (zero_hit && mode_sel[0]) |=> wave_level != $past(wave_level)); // R10
    AST_LOAD_LOW: assert property (@(posedge clk) disable iff (rst)
        load |=> !wave_level); // R9
    AST_PIN_PASS: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel[1] || !pin_dir7) |-> pin_out7 == pin_data7); // R11
endmodule

bind timer16_latched timer16_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .mode_sel    (mode_sel),
    .pin_dir7    (pin_dir7),
    .pin_data7   (pin_data7),
    .irq_flag    (irq_flag),
    .pin_out7    (pin_out7),
    .cnt         (cnt_q),
    .latch       (latch_q),
    .reload_pend (reload_pend),
    .zero_hit    (zero_hit),
    .armed       (armed),
    .wave_level  (wave_level)
);

// File: tb/sim_timer16_latched.sv
`timescale 1ns/1ps
module sim_timer16_latched;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [1:0] mode_sel = 2'b10;
    logic       pin_dir7 = 1'b1;
    logic       pin_data7 = 1'b0;
    logic       irq_flag;
    logic       pin_out7;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    timer16_latched u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .mode_sel(mode_sel), .pin_dir7(pin_dir7), .pin_data7(pin_data7),
        .irq_flag(irq_flag), .pin_out7(pin_out7)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic peek_cnt(output logic [15:0] v);
        logic [7:0] b;
        peek(2'd1, b); v[15:8] = b;
        peek(2'd0, b); v[7:0] = b;
    endtask

    task automatic load(logic [15:0] n, logic [1:0] m);
        wr(2'd0, n[7:0]);
        mode_sel = m;
        wr(2'd1, n[15:8]);
    endtask

    function automatic logic [15:0] exp_cnt(int n, int k, bit cont);
        int p;
        if (!cont) return 16'(n - k);
        p = k % (n + 2);
        return (p <= n) ? 16'(n - p) : 16'hFFFF;
    endfunction

    function automatic logic exp_level(int n, int k, bit cont);
        int z;
        if (k < n + 1) return 1'b0;
        if (!cont) return 1'b1;
        z = (k - n - 1) / (n + 2) + 1;
        return z[0];
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] c0, c1;
        bit seen;
        void'($urandom(32'd2024));

        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 flag", irq_flag, 0);
        chk("R1 level", pin_out7, 1);
        peek(2'd2, b); chk("R1 lat_lo", b, 0);
        peek(2'd3, b); chk("R1 lat_hi", b, 0);

        // R11 pin mux
        mode_sel = 2'b00; pin_dir7 = 1; pin_data7 = 1; #1;
        chk("R11 no wave mode", pin_out7, 1);
        pin_data7 = 0; #1;
        chk("R11 no wave mode data0", pin_out7, 0);
        mode_sel = 2'b10; pin_dir7 = 0; #1;
        chk("R11 dir input", pin_out7, 0);
        pin_dir7 = 1; #1;
        chk("R11 wave driven", pin_out7, 1);
        tick(1);

        // R2 low latch writes leave counter decrementing
        peek_cnt(c0);
        wr(2'd2, 8'hA5);
        peek(2'd2, b); chk("R2 off2 write", b, 8'hA5);
        peek_cnt(c1); chk("R2 counter untouched", c1, c0 - 16'd1);
        wr(2'd0, 8'h3C);
        peek(2'd2, b); chk("R2 off0 write", b, 8'h3C);

        // one-shot N=5
        load(16'd5, 2'b10);
        peek_cnt(c0); chk("R3 load value", c0, 16'd5);
        chk("R9 level low after load", pin_out7, 0);
        chk("R3 flag cleared", irq_flag, 0);
        tick(5);
        peek_cnt(c0); chk("R6 counter zero", c0, 0);
        chk("R6 flag not yet", irq_flag, 0);
        tick(1);
        chk("R6 flag set", irq_flag, 1);
        chk("R9 level high at zero", pin_out7, 1);
        peek_cnt(c0); chk("R6 counter wraps", c0, 16'hFFFF);
        rd(2'd1); rd(2'd2); rd(2'd3);
        chk("R5 other reads keep flag", irq_flag, 1);
        rd(2'd0);
        chk("R5 offset0 read clears", irq_flag, 0);
        // R7 full wrap, no second flag
        seen = 0;
        for (int i = 0; i < 65540; i++) begin
            tick(1);
            if (irq_flag) seen = 1;
        end
        chk("R7 no re-fire after wrap", seen, 0);

        // free-running N=3
        load(16'd3, 2'b11);
        tick(3);
        peek_cnt(c0); chk("R8 at zero", c0, 0);
        tick(1);
        peek_cnt(c0); chk("R8 post-zero FFFF", c0, 16'hFFFF);
        chk("R10 first toggle", pin_out7, 1);
        tick(1);
        peek_cnt(c0); chk("R8 reload", c0, 16'd3);
        wr(2'd3, 8'h00);
        chk("R4 flag cleared", irq_flag, 0);
        peek(2'd3, b); chk("R4 hi latch", b, 8'h00);
        peek_cnt(c0); chk("R4 counter untouched", c0, 16'd2);
        tick(2);
        peek_cnt(c0); chk("R12 counter zero before race", c0, 0);
        rd(2'd0);
        chk("R12 set beats read clear", irq_flag, 1);
        chk("R10 second toggle", pin_out7, 0);

        // random loads in both modes
        for (int it = 0; it < 24; it++) begin
            int n;
            bit cont;
            n = 2 + int'($urandom % 50);
            cont = 1'($urandom % 2);
            load(16'(n), {1'b1, cont});
            for (int k = 1; k <= 3 * (n + 2); k++) begin
                tick(1);
                peek_cnt(c0);
                chk(cont ? "R8 free count" : "R3 one-shot count", c0, exp_cnt(n, k, cont));
                chk("R6 flag timing", irq_flag, (k >= n + 1) ? 1 : 0);
                chk(cont ? "R10 square wave" : "R9 pulse", pin_out7, exp_level(n, k, cont));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule